// File: doc/BRIEF.md
# Dual-Mode Interleaved CORDIC Pipeline

This block is a circular CORDIC engine with a fixed number of iteration stages. It performs two conversions in the same stages. Vectoring turns an I/Q pair into magnitude and phase. Rotation turns a vector plus an angle into rotated I/Q. Every sample carries its own mode tag through the pipeline, so each stage picks its direction rule from the sample it holds. A vectoring sample and a rotation sample can therefore enter on consecutive cycles, and each conversion sustains one sample every two cycles.

The first register folds inputs that lie outside the iteration's convergence range back into it by a quarter-turn, and records the turn in the angle accumulator. The last register removes the CORDIC gain with a constant multiply and clips x, y and z to the output width. A valid flag travels alongside the data. Cycles in which the valid flag is low produce idle output cycles.

Top module: `cordic_dual_pipe`

## Requirements
- R1: A sample presented with `in_vld` high appears with `out_vld` high exactly STAGES+2 cycles later (15 with defaults). No sample is lost or duplicated.
- R2: In vectoring mode, `out_x` equals sqrt(x²+y²) and `out_z` equals atan2(y, x) over the full ±π range, each within 16 LSB. x and y use 13 fraction bits (8192 = 1.0), and the phase is in radians with 13 fraction bits. This holds for magnitudes of at least 0.25.
- R3: In vectoring mode, `out_y` is within 32 LSB of zero, and the value on `in_z` has no effect on any output.
- R4: In rotation mode, `out_x` equals x·cos z − y·sin z and `out_y` equals x·sin z + y·cos z, each within 16 LSB, for |z| ≤ π.
- R5: In rotation mode, angles beyond ±π/2 are handled correctly, and `out_z` is within 16 LSB of zero.
- R6: The mode is decided per sample, with `in_mode` = 1 for vectoring and 0 for rotation. `out_mode` returns the tag of the sample it accompanies. Samples of alternating modes on consecutive cycles do not disturb one another.
- R7: Results beyond the output range clip to +32767 or −32768 instead of wrapping. A vectoring magnitude is never negative.
- R8: After a synchronous active-low reset, and for every cycle that carries no sample, `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Sample present this cycle |
| in_mode | input | 1 | 1 = vectoring, 0 = rotation |
| in_x | input | DW | I, or amplitude / vector x |
| in_y | input | DW | Q, or vector y |
| in_z | input | DW | Rotation angle (ignored in vectoring) |
| out_vld | output | 1 | Result present this cycle |
| out_mode | output | 1 | Mode tag of the result |
| out_x | output | DW | Magnitude, or rotated x |
| out_y | output | DW | Residual (vectoring), or rotated y |
| out_z | output | DW | Phase (vectoring), or residual angle |

## Verification
The two functions that meet in the same cycle are the vectoring and rotation rules. When modes alternate, neighbouring stages hold samples of opposite mode at the same moment. The bench provokes this by switching `in_mode` every cycle with random operands, and with gaps and quadrant-edge cases mixed in. A behavioural model built on real arithmetic and a queue of due cycles judges every output cycle against the math of that sample's own tag. Any mix-up of direction rules between adjacent stages shows up as a large numeric error, or as a wrong tag on the result.

// File: rtl/cordic_dual_pkg.sv
// Shared constants and helpers for the dual-mode CORDIC pipeline.
// Assumes the phase is in radians with PH_FRAC fraction bits.
package cordic_dual_pkg;

    typedef enum logic {
        MODE_ROT = 1'b0,
        MODE_VEC = 1'b1
    } cordic_mode_e;

    localparam int PH_FRAC       = 13;
    localparam int HALF_PI       = 12868;   // pi/2 * 2^13
    localparam int INV_GAIN      = 19898;   // 1/K * 2^15
    localparam int INV_GAIN_FRAC = 15;

    // Arctangent of 2^-i, scaled to the phase format.
    function automatic int atan_step(input int i);
        case (i)
            0:  return 6434;
            1:  return 3798;
            2:  return 2007;
            3:  return 1019;
            4:  return 511;
            5:  return 256;
            6:  return 128;
            7:  return 64;
            8:  return 32;
            9:  return 16;
            10: return 8;
            11: return 4;
            12: return 2;
            default: return (i < 31) ? ((1 << PH_FRAC) >> i) : 0;
        endcase
    endfunction

endpackage

// File: rtl/cordic_dual_fold.sv
// Entry register. Folds each sample into the convergence range of the
// iterations by a quarter-turn and seeds the angle accumulator.
// Vectoring: negative x is turned by -/+90 degrees and z starts at +/-pi/2.
// Rotation: |z| > pi/2 is turned by +/-90 degrees and z is reduced.
// Assumes a rotation angle of |z| <= pi.
module cordic_dual_fold
    import cordic_dual_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = DW + 3,
    parameter int ZW = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_mode,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic signed [DW-1:0] in_z,
    output logic                 o_vld,
    output logic                 o_mode,
    output logic signed [IW-1:0] o_x,
    output logic signed [IW-1:0] o_y,
    output logic signed [ZW-1:0] o_z
);
    localparam logic signed [ZW-1:0] HP = ZW'(HALF_PI);

    logic signed [IW-1:0] xe, ye, xf, yf;
    logic signed [ZW-1:0] ze, zf;

    assign xe = IW'(in_x);
    assign ye = IW'(in_y);
    assign ze = ZW'(in_z);

    // Pick the quarter-turn for this sample's mode.
    always_comb begin
        xf = xe;
        yf = ye;
        zf = ze;
        if (in_mode == MODE_VEC) begin
            zf = '0;
            if (xe < 0) begin
                if (ye >= 0) begin
                    xf = ye;
                    yf = -xe;
                    zf = HP;
                end else begin
                    xf = -ye;
                    yf = xe;
                    zf = -HP;
                end
            end
        end else begin
            if (ze > HP) begin
                xf = -ye;
                yf = xe;
                zf = ze - HP;
            end else if (ze < -HP) begin
                xf = ye;
                yf = -xe;
                zf = ze + HP;
            end
        end
    end

    // Register the folded sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_mode <= 1'b0;
            o_x    <= '0;
            o_y    <= '0;
            o_z    <= '0;
        end else begin
            o_vld  <= in_vld;
            o_mode <= in_mode;
            o_x    <= xf;
            o_y    <= yf;
            o_z    <= zf;
        end
    end
endmodule

// File: rtl/cordic_dual_stage.sv
// One CORDIC micro-rotation by atan(2^-SHIFT). The direction comes from
// the sample's own mode tag: vectoring drives y toward 0, rotation
// drives z toward 0. Assumes the inputs are already in range.
module cordic_dual_stage
    import cordic_dual_pkg::*;
#(
    parameter int IW    = 19,
    parameter int ZW    = 17,
    parameter int SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_vld,
    input  logic                 i_mode,
    input  logic signed [IW-1:0] i_x,
    input  logic signed [IW-1:0] i_y,
    input  logic signed [ZW-1:0] i_z,
    output logic                 o_vld,
    output logic                 o_mode,
    output logic signed [IW-1:0] o_x,
    output logic signed [IW-1:0] o_y,
    output logic signed [ZW-1:0] o_z
);
    localparam logic signed [ZW-1:0] ANG = ZW'(atan_step(SHIFT));

    logic                 turn_pos;
    logic signed [IW-1:0] xs, ys;

    assign xs = i_x >>> SHIFT;
    assign ys = i_y >>> SHIFT;

    // Direction rule selected by the sample's tag.
    assign turn_pos = (i_mode == MODE_VEC) ? (i_y < 0) : (i_z >= 0);

    // Apply the micro-rotation and advance the tag with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_mode <= 1'b0;
            o_x    <= '0;
            o_y    <= '0;
            o_z    <= '0;
        end else begin
            o_vld  <= i_vld;
            o_mode <= i_mode;
            if (turn_pos) begin
                o_x <= i_x - ys;
                o_y <= i_y + xs;
                o_z <= i_z - ANG;
            end else begin
                o_x <= i_x + ys;
                o_y <= i_y - xs;
                o_z <= i_z + ANG;
            end
        end
    end
endmodule

// File: rtl/cordic_dual_scale.sv
// Exit register. Multiplies x and y by 1/K with rounding, then clips
// x, y and z to the DW-bit output range. Assumes the iteration count
// is large enough that the gain constant has settled.
module cordic_dual_scale
    import cordic_dual_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = DW + 3,
    parameter int ZW = DW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_vld,
    input  logic                 i_mode,
    input  logic signed [IW-1:0] i_x,
    input  logic signed [IW-1:0] i_y,
    input  logic signed [ZW-1:0] i_z,
    output logic                 o_vld,
    output logic                 o_mode,
    output logic signed [DW-1:0] o_x,
    output logic signed [DW-1:0] o_y,
    output logic signed [DW-1:0] o_z
);
    localparam int PW = IW + INV_GAIN_FRAC + 2;
    localparam logic signed [PW-1:0] GAIN = PW'(INV_GAIN);
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (INV_GAIN_FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (DW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] px, py, sx, sy;

    // Clip a wide value into the output width.
    function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
        if (v > MAXV)      return DW'(MAXV);
        else if (v < MINV) return DW'(MINV);
        else               return DW'(v);
    endfunction

    assign px = PW'(i_x) * GAIN;
    assign py = PW'(i_y) * GAIN;
    assign sx = (px + HALF) >>> INV_GAIN_FRAC;
    assign sy = (py + HALF) >>> INV_GAIN_FRAC;

    // Register the gain-corrected, clipped result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_mode <= 1'b0;
            o_x    <= '0;
            o_y    <= '0;
            o_z    <= '0;
        end else begin
            o_vld  <= i_vld;
            o_mode <= i_mode;
            o_x    <= clip(sx);
            o_y    <= clip(sy);
            o_z    <= clip(PW'(i_z));
        end
    end
endmodule

// File: rtl/cordic_dual_pipe.sv
// Dual-mode circular CORDIC pipeline: fold register, STAGES micro-rotation
// stages and a gain/clip register. The latency is STAGES+2 cycles. Each
// sample's mode tag rides with it, so the modes may interleave every cycle.
module cordic_dual_pipe
    import cordic_dual_pkg::*;
#(
    parameter int DW     = 16,
    parameter int STAGES = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic                 in_mode,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic signed [DW-1:0] in_z,
    output logic                 out_vld,
    output logic                 out_mode,
    output logic signed [DW-1:0] out_x,
    output logic signed [DW-1:0] out_y,
    output logic signed [DW-1:0] out_z
);
    localparam int IW = DW + 3;
    localparam int ZW = DW + 1;

    logic                 vld_p  [0:STAGES];
    logic                 mode_p [0:STAGES];
    logic signed [IW-1:0] x_p    [0:STAGES];
    logic signed [IW-1:0] y_p    [0:STAGES];
    logic signed [ZW-1:0] z_p    [0:STAGES];

    cordic_dual_fold #(.DW(DW), .IW(IW), .ZW(ZW)) u_fold (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_mode(in_mode),
        .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .o_vld(vld_p[0]), .o_mode(mode_p[0]),
        .o_x(x_p[0]), .o_y(y_p[0]), .o_z(z_p[0])
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_iter
        cordic_dual_stage #(.IW(IW), .ZW(ZW), .SHIFT(g)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .i_vld(vld_p[g]), .i_mode(mode_p[g]),
            .i_x(x_p[g]), .i_y(y_p[g]), .i_z(z_p[g]),
            .o_vld(vld_p[g+1]), .o_mode(mode_p[g+1]),
            .o_x(x_p[g+1]), .o_y(y_p[g+1]), .o_z(z_p[g+1])
        );
    end

    cordic_dual_scale #(.DW(DW), .IW(IW), .ZW(ZW)) u_scale (
        .clk(clk), .rst_n(rst_n),
        .i_vld(vld_p[STAGES]), .i_mode(mode_p[STAGES]),
        .i_x(x_p[STAGES]), .i_y(y_p[STAGES]), .i_z(z_p[STAGES]),
        .o_vld(out_vld), .o_mode(out_mode),
        .o_x(out_x), .o_y(out_y), .o_z(out_z)
    );
endmodule

// File: rtl/cordic_dual_chk.sv
// Property checker for cordic_dual_pipe. It keeps its own LAT-deep record
// of the input flags and holds the outputs against it.
module cordic_dual_chk #(
    parameter int DW  = 16,
    parameter int LAT = 15
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_vld,
    input logic                 in_mode,
    input logic                 out_vld,
    input logic                 out_mode,
    input logic signed [DW-1:0] out_x,
    input logic signed [DW-1:0] out_y,
    input logic signed [DW-1:0] out_z
);
    logic [LAT-1:0] vsr, msr;

    // Delay line of the input flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsr <= '0;
            msr <= '0;
        end else begin
            vsr <= {vsr[LAT-2:0], in_vld};
            msr <= {msr[LAT-2:0], in_mode};
        end
    end

    // R1
    lat_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == vsr[LAT-1]);

    // R6
    mode_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_mode == msr[LAT-1]));

    // R3
    vec_resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_mode) |-> (out_y <= 32 && out_y >= -32));

    // R5
    rot_resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_mode) |-> (out_z <= 16 && out_z >= -16));

    // R7
    mag_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_mode) |-> !out_x[DW-1]);

    // R8
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_vld);
endmodule

bind cordic_dual_pipe cordic_dual_chk #(.DW(DW), .LAT(STAGES + 2)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_vld(in_vld), .in_mode(in_mode),
    .out_vld(out_vld), .out_mode(out_mode),
    .out_x(out_x), .out_y(out_y), .out_z(out_z)
);

// File: tb/cordic_dual_pipe_bench.sv
`timescale 1ns/1ps
module cordic_dual_pipe_bench;
    localparam int  DW   = 16;
    localparam int  ST   = 13;
    localparam int  LAT  = ST + 2;
    localparam int  TOL  = 16;
    localparam int  YTOL = 32;
    localparam real SC   = 8192.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0, in_mode = 1'b0;
    logic signed [DW-1:0] in_x = '0, in_y = '0, in_z = '0;
    logic out_vld, out_mode;
    logic signed [DW-1:0] out_x, out_y, out_z;

    always #2 clk = ~clk;

    cordic_dual_pipe #(.DW(DW), .STAGES(ST)) u_cordic_dual_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_mode(in_mode),
        .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .out_vld(out_vld), .out_mode(out_mode),
        .out_x(out_x), .out_y(out_y), .out_z(out_z)
    );

    typedef struct {
        int due;
        bit mode;
        int ex;
        int ey;
        int ez;
        bit sat;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    function automatic int clamp(input int v);
        return (v > 32767) ? 32767 : ((v < -32768) ? -32768 : v);
    endfunction

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Drive one cycle and queue the expected result from real arithmetic.
    task automatic send(input bit v, input bit m, input int x, input int y, input int z);
        exp_t e;
        real xr, yr, zr, a, b;
        @(negedge clk);
        in_vld  = v;
        in_mode = m;
        in_x    = DW'(x);
        in_y    = DW'(y);
        in_z    = DW'(z);
        if (v) begin
            xr = x; yr = y; zr = z / SC;
            e.due  = cyc + LAT;
            e.mode = m;
            if (m) begin
                a = $sqrt(xr * xr + yr * yr);
                e.ex  = clamp(rnd(a));
                e.ey  = 0;
                e.ez  = rnd($atan2(yr, xr) * SC);
                e.sat = (a > 32767.0);
            end else begin
                a = xr * $cos(zr) - yr * $sin(zr);
                b = xr * $sin(zr) + yr * $cos(zr);
                e.ex  = clamp(rnd(a));
                e.ey  = clamp(rnd(b));
                e.ez  = 0;
                e.sat = (absi(rnd(a)) > 32767) || (absi(rnd(b)) > 32767);
            end
            q.push_back(e);
        end
    endtask

    // Compare every output cycle against the model.
    always @(negedge clk) begin
        exp_t e;
        string rx, ry, rz;
        if (rst_n) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                e = q.pop_front();
                chk(out_vld == 1'b1, "R1", int'(out_vld), 1);
                chk(out_mode == e.mode, "R6", int'(out_mode), int'(e.mode));
                rx = e.sat ? "R7" : (e.mode ? "R2" : "R4");
                ry = e.sat ? "R7" : (e.mode ? "R3" : "R4");
                rz = e.mode ? "R2" : "R5";
                chk(absi(int'(out_x) - e.ex) <= TOL, rx, int'(out_x), e.ex);
                chk(absi(int'(out_y) - e.ey) <= (e.mode ? YTOL : TOL), ry, int'(out_y), e.ey);
                chk(absi(int'(out_z) - e.ez) <= TOL, rz, int'(out_z), e.ez);
            end else begin
                chk(out_vld == 1'b0, "R8", int'(out_vld), 0);
            end
        end
    end

    function automatic int urange(input int lo, input int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    task automatic rand_vec(output int x, output int y);
        do begin
            x = urange(-22000, 22000);
            y = urange(-22000, 22000);
        end while ((x * x + y * y) < 2500 * 2500);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int x, y;
        // R8: reset state
        repeat (3) @(negedge clk);
        chk(out_vld == 1'b0, "R8", int'(out_vld), 0);
        rst_n = 1'b1;

        // R2 R3: vectoring in every quadrant, nonzero in_z must be ignored
        send(1, 1, 8192, 0, 5000);
        send(1, 1, 0, 8192, -7000);
        send(1, 1, -8192, 0, 12000);
        send(1, 1, -4096, -5734, 300);
        send(1, 1, 2458, -7373, -20000);
        send(1, 1, -6000, 3000, 25000);

        // R4 R5: rotation, including angles past +/-pi/2
        send(1, 0, 8192, 0, 0);
        send(1, 0, 8192, 0, 12868);
        send(1, 0, 4096, 2048, 25000);
        send(1, 0, 4096, -2048, -25000);
        send(1, 0, 6000, 0, -13000);
        send(1, 0, 3000, 1000, 13500);

        // R7: clipping in both modes
        send(1, 1, 30000, 30000, 0);
        send(1, 1, -30000, -30000, 0);
        send(1, 0, 30000, 30000, 6434);
        send(1, 0, 30000, -30000, -6434);

        // R6: alternate modes every cycle with random operands
        for (int k = 0; k < 60; k++) begin
            rand_vec(x, y);
            send(1, k[0], x, y, urange(-25700, 25700));
        end

        // R8: gaps between samples, idle cycles carry random data
        for (int k = 0; k < 45; k++) begin
            rand_vec(x, y);
            send((k % 3) != 0, (k % 4) < 2, x, y, urange(-25700, 25700));
        end

        // R2 R4: long runs of one mode
        for (int k = 0; k < 30; k++) begin
            rand_vec(x, y);
            send(1, 1, x, y, urange(-25700, 25700));
        end
        for (int k = 0; k < 30; k++) begin
            rand_vec(x, y);
            send(1, 0, x, y, urange(-25700, 25700));
        end

        send(0, 0, 0, 0, 0);
        repeat (LAT + 4) @(negedge clk);
        // R1: every queued sample must have come out
        chk(q.size() == 0, "R1", q.size(), 0);
        finish_run();
    end
endmodule